// File: doc/BRIEF.md
# Buffered-Period PWM Counter

This block is the timebase of one pulse-width-modulation channel. A counter of parameterised width (16 bits by default) runs in one of two shapes. In count-down mode it falls to zero and then reloads the period. In up/down mode it climbs from zero to the period and then falls back to zero. The period is never written straight into the counter. A register write lands in a pending register, and the value moves into the active register only when the counter reaches zero. Software can therefore change the period at any time without producing a short or torn cycle.

A control input selects when that move happens. In immediate update mode the move happens at the next counter zero. In synchronous mode the move also waits for a chip-wide synchronous-update request pulse. Several channels (three by default slot assignment) can share that pulse, so their new periods take effect together. Each instance answers at one address of a 0x40-spaced register window, chosen by its slot parameter. Its outputs are the counter value, a zero-reached pulse and a load-reached (peak) pulse.

Top module: `pwm_buffered_period`

## Requirements
- R1: While reset is low, count, the active period and the pending period are all 0, and rd_data reads 0.
- R2: A write with wr_en high and wr_addr equal to BASE_ADDR + SLOT*STRIDE (0x050, 0x090, 0x0D0 for slots 0, 1, 2) stores wr_data in the pending period. A write to any other address changes nothing. rd_data always shows the pending period in bits 15:0, and bits 31:16 read 0.
- R3: In count-down mode (mode_updown = 0), count falls by 1 on each enabled clock. On the clock after count is 0, count loads the period.
- R4: In up/down mode (mode_updown = 1), count rises by 1 from 0 until it equals the active period, then falls by 1 back to 0, and repeats. load_pulse is 1 exactly when enable is 1, mode_updown is 1, the active period is nonzero and count equals it.
- R5: zero_pulse is 1 exactly when enable is 1 and count is 0.
- R6: With sync_mode = 0, a pending period that has not yet been applied becomes the active period at the next enabled clock on which count is 0. The counter then loads it on that same clock.
- R7: With sync_mode = 1, a pending period is applied only at the first zero clock that follows a clock on which sync_req was 1. The request is held until a zero clock consumes it. A request made while no period is pending and none is being written is dropped.
- R8: A second write before the pending period is applied replaces it, and the earlier value is never loaded.
- R9: With an active period of 0, count stays at 0 and zero_pulse is 1 on every enabled clock.
- R10: With enable = 0, count holds its value and both pulses are 0. Writes to the pending period still take effect.
- R11: count never exceeds the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counter run enable |
| mode_updown | input | 1 | 0 = count-down with reload, 1 = up then down |
| sync_mode | input | 1 | 0 = immediate period update, 1 = wait for sync request |
| sync_req | input | 1 | Shared synchronous-update request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 16 | New period value |
| count | output | 16 | Current counter value |
| zero_pulse | output | 1 | Counter is at zero on an enabled clock |
| load_pulse | output | 1 | Up/down counter is at the active period |
| rd_data | output | 32 | Read-back of the pending period register |

## Verification
The assertions assume the counter never starts a run above the active period. This holds because reset clears both, and the active period changes only on a zero clock. They also assume that mode_updown changes only on a clock edge. This is because the count-down step property compares one edge with the next. The stimulus table changes mode only once, at a point where the count already lies at or below the period. All inputs are driven half a cycle away from the sampling edge. Sync requests in the directed part are placed both with and without a pending value, to exercise the drop case.

// File: rtl/pwm_cnt_pkg.sv
package pwm_cnt_pkg;

   // Byte address of the load register for a given generator slot.
   function automatic logic [11:0] slot_addr(input logic [11:0] base,
                                             input logic [11:0] stride,
                                             input int unsigned slot);
      return base + stride * slot[11:0];
   endfunction

   typedef enum logic {
      UPD_IMMEDIATE = 1'b0,
      UPD_SYNC      = 1'b1
   } upd_mode_e;

endpackage

// File: rtl/pwm_load_buffer.sv
module pwm_load_buffer #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned REG_W     = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter logic [11:0] LOAD_ADDR = 12'h050
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              sync_mode,
   input  logic              sync_req,
   input  logic              zero_evt,
   output logic [CNT_W-1:0]  reload_val,
   output logic [CNT_W-1:0]  active_val,
   output logic [REG_W-1:0]  rd_data
);
   import pwm_cnt_pkg::*;

   localparam int unsigned PAD_W = REG_W - CNT_W;

   logic [CNT_W-1:0] pend_q, act_q;
   logic             pend_vld_q, sync_lat_q;
   logic             wr_hit, apply;
   upd_mode_e        upd_mode;

   assign upd_mode = upd_mode_e'(sync_mode);
   assign wr_hit   = wr_en && (wr_addr == LOAD_ADDR[ADDR_W-1:0]);
   assign apply    = zero_evt && pend_vld_q &&
                     ((upd_mode == UPD_IMMEDIATE) || sync_lat_q);

   assign reload_val = apply ? pend_q : act_q;
   assign active_val = act_q;
   assign rd_data    = {{PAD_W{1'b0}}, pend_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= '0;
         act_q      <= '0;
         pend_vld_q <= 1'b0;
         sync_lat_q <= 1'b0;
      end else begin
         if (wr_hit)
            pend_q <= wr_data;
         if (apply)
            act_q <= pend_q;
         if (wr_hit)
            pend_vld_q <= 1'b1;
         else if (apply)
            pend_vld_q <= 1'b0;
         if (sync_req && (pend_vld_q || wr_hit))
            sync_lat_q <= 1'b1;
         else if (zero_evt)
            sync_lat_q <= 1'b0;
      end
   end

   // R6: the active period moves only on a zero clock
   p_active_at_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !zero_evt |=> $stable(act_q));

   // R7: in synchronous mode with no held request, the active period holds
   p_sync_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !sync_lat_q) |=> $stable(act_q));

   // R2: reserved read-back bits stay zero
   p_rsvd_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:CNT_W] == '0);

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
   parameter int unsigned CNT_W     = 16,
   parameter bit          UPDOWN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             mode_updown,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] active_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt,
   output logic             peak_hit
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             up_q, up_d;
   logic             at_zero;

   assign at_zero  = (cnt_q == '0);
   assign zero_evt = enable && at_zero;
   assign count    = cnt_q;

   generate
      if (UPDOWN_EN) begin : g_updown
         always_comb begin
            cnt_d = cnt_q;
            up_d  = up_q;
            if (enable) begin
               if (!mode_updown) begin
                  cnt_d = at_zero ? reload_val : cnt_q - ONE;
               end else if (at_zero) begin
                  cnt_d = (reload_val == '0) ? '0 : ONE;
                  up_d  = 1'b1;
               end else if (up_q && (cnt_q < active_val)) begin
                  cnt_d = cnt_q + ONE;
               end else begin
                  cnt_d = cnt_q - ONE;
                  up_d  = 1'b0;
               end
            end
         end
         assign peak_hit = enable && mode_updown && (active_val != '0) &&
                           (cnt_q == active_val);
      end else begin : g_down_only
         always_comb begin
            cnt_d = cnt_q;
            up_d  = 1'b0;
            if (enable)
               cnt_d = at_zero ? reload_val : cnt_q - ONE;
         end
         assign peak_hit = 1'b0 & mode_updown & active_val[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
      end
   end

   // R10: a disabled counter holds
   p_freeze_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(cnt_q));

   // R3: count-down mode steps by one away from zero
   p_down_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !mode_updown && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/pwm_buffered_period.sv
module pwm_buffered_period #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned REG_W     = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_SLOTS = 3,
   parameter int unsigned SLOT      = 0,
   parameter logic [11:0] BASE_ADDR = 12'h050,
   parameter logic [11:0] STRIDE    = 12'h040,
   parameter bit          UPDOWN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              mode_updown,
   input  logic              sync_mode,
   input  logic              sync_req,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count,
   output logic              zero_pulse,
   output logic              load_pulse,
   output logic [REG_W-1:0]  rd_data
);
   import pwm_cnt_pkg::*;

   localparam logic [11:0] LOAD_ADDR = slot_addr(BASE_ADDR, STRIDE, SLOT);

   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_width
         $error("CNT_W must lie between 2 and REG_W");
      end
      if (SLOT >= NUM_SLOTS) begin : g_bad_slot
         $error("SLOT must be below NUM_SLOTS");
      end
      if (ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W is limited to 12 bits");
      end
   endgenerate

   logic [CNT_W-1:0] reload_val, active_val;
   logic             zero_evt, peak_hit;

   pwm_load_buffer #(
      .CNT_W    (CNT_W),
      .REG_W    (REG_W),
      .ADDR_W   (ADDR_W),
      .LOAD_ADDR(LOAD_ADDR)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .sync_mode (sync_mode),
      .sync_req  (sync_req),
      .zero_evt  (zero_evt),
      .reload_val(reload_val),
      .active_val(active_val),
      .rd_data   (rd_data)
   );

   pwm_count_core #(
      .CNT_W    (CNT_W),
      .UPDOWN_EN(UPDOWN_EN)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .mode_updown(mode_updown),
      .reload_val (reload_val),
      .active_val (active_val),
      .count      (count),
      .zero_evt   (zero_evt),
      .peak_hit   (peak_hit)
   );

   assign zero_pulse = zero_evt;
   assign load_pulse = peak_hit;

   // R11: the counter never runs past the active period
   p_bound_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= active_val);

   // R9: a zero period pins the counter at zero
   p_zero_period_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (active_val == '0 && reload_val == '0 && enable) |=> (count == '0));

endmodule

// File: tb/tb_pwm_buffered_period.sv
module tb_pwm_buffered_period;

   localparam logic [11:0] A_OWN   = 12'h050;
   localparam logic [11:0] A_OTHER = 12'h090;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, mode_updown = 1'b0, sync_mode = 1'b0;
   logic        sync_req = 1'b0, wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] count;
   logic        zero_pulse, load_pulse;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pwm_buffered_period dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode_updown(mode_updown),
      .sync_mode(sync_mode), .sync_req(sync_req), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
      .zero_pulse(zero_pulse), .load_pulse(load_pulse), .rd_data(rd_data)
   );

   typedef struct packed {
      logic        en;
      logic        ud;
      logic        sm;
      logic        sr;
      logic        we;
      logic [11:0] addr;
      logic [15:0] data;
      logic [15:0] ecnt;
      logic        ez;
      logic        el;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{1,0,0,0,1,A_OWN,16'd3,16'd0,1,0,4'd9},  // 0  R9 zero period, write 3
      '{1,0,0,0,0,A_OWN,16'd0,16'd3,0,0,4'd6},  // 1  R6 applied at zero
      '{1,0,0,0,0,A_OWN,16'd0,16'd2,0,0,4'd3},  // 2  R3
      '{1,0,0,0,0,A_OWN,16'd0,16'd1,0,0,4'd3},  // 3
      '{1,0,0,0,0,A_OWN,16'd0,16'd0,1,0,4'd5},  // 4  R5
      '{1,0,0,0,0,A_OWN,16'd0,16'd3,0,0,4'd3},  // 5  R3 reload
      '{1,0,0,0,1,A_OWN,16'd5,16'd2,0,0,4'd6},  // 6  write 5 mid-run
      '{1,0,0,0,0,A_OWN,16'd0,16'd1,0,0,4'd6},  // 7
      '{1,0,0,0,0,A_OWN,16'd0,16'd0,1,0,4'd5},  // 8
      '{1,0,0,0,0,A_OWN,16'd0,16'd5,0,0,4'd6},  // 9  R6 new period
      '{1,0,1,0,1,A_OWN,16'd2,16'd4,0,0,4'd7},  // 10 R7 sync write 2
      '{1,0,1,0,0,A_OWN,16'd0,16'd3,0,0,4'd7},  // 11
      '{1,0,1,0,0,A_OWN,16'd0,16'd2,0,0,4'd7},  // 12
      '{1,0,1,0,0,A_OWN,16'd0,16'd1,0,0,4'd7},  // 13
      '{1,0,1,0,0,A_OWN,16'd0,16'd0,1,0,4'd7},  // 14
      '{1,0,1,0,0,A_OWN,16'd0,16'd5,0,0,4'd7},  // 15 R7 held, old period
      '{1,0,1,1,0,A_OWN,16'd0,16'd4,0,0,4'd7},  // 16 sync request
      '{1,0,1,0,0,A_OWN,16'd0,16'd3,0,0,4'd7},  // 17
      '{1,0,1,0,0,A_OWN,16'd0,16'd2,0,0,4'd7},  // 18
      '{1,0,1,0,0,A_OWN,16'd0,16'd1,0,0,4'd7},  // 19
      '{1,0,1,0,0,A_OWN,16'd0,16'd0,1,0,4'd7},  // 20
      '{1,0,1,0,0,A_OWN,16'd0,16'd2,0,0,4'd7},  // 21 R7 applied
      '{1,0,0,0,1,A_OWN,16'd4,16'd1,0,0,4'd8},  // 22 R8 write 4
      '{1,0,0,0,1,A_OWN,16'd6,16'd0,1,0,4'd8},  // 23 R8 overwrite 6
      '{1,0,0,0,0,A_OWN,16'd0,16'd6,0,0,4'd8},  // 24 R8 only 6 used
      '{1,1,0,0,1,A_OWN,16'd2,16'd5,0,0,4'd4},  // 25 R4 switch to up/down
      '{1,1,0,0,0,A_OWN,16'd0,16'd4,0,0,4'd4},  // 26
      '{1,1,0,0,0,A_OWN,16'd0,16'd3,0,0,4'd4},  // 27
      '{1,1,0,0,0,A_OWN,16'd0,16'd2,0,0,4'd4},  // 28
      '{1,1,0,0,0,A_OWN,16'd0,16'd1,0,0,4'd4},  // 29
      '{1,1,0,0,0,A_OWN,16'd0,16'd0,1,0,4'd4},  // 30
      '{1,1,0,0,0,A_OWN,16'd0,16'd1,0,0,4'd4},  // 31 R4 climb, period 2
      '{1,1,0,0,0,A_OWN,16'd0,16'd2,0,1,4'd4},  // 32 R4 peak pulse
      '{1,1,0,0,0,A_OWN,16'd0,16'd1,0,0,4'd4},  // 33
      '{1,1,0,0,0,A_OWN,16'd0,16'd0,1,0,4'd4},  // 34
      '{1,1,0,0,0,A_OWN,16'd0,16'd1,0,0,4'd4}   // 35
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic en, input logic ud, input logic sm, input logic sr,
                        input logic we, input logic [11:0] ad, input logic [15:0] dt);
      @(negedge clk);
      enable = en; mode_updown = ud; sync_mode = sm; sync_req = sr;
      wr_en = we; wr_addr = ad; wr_data = dt;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      enable = 1'b0; sync_req = 1'b0; wr_en = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 count", {16'd0, count}, 32'd0);
      chk("R1 rd_data", rd_data, 32'd0);
      chk("R5 zero while disabled", {31'd0, zero_pulse}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].en, VEC[i].ud, VEC[i].sm, VEC[i].sr,
               VEC[i].we, VEC[i].addr, VEC[i].data);
         checks++;
         if (count !== VEC[i].ecnt || zero_pulse !== VEC[i].ez || load_pulse !== VEC[i].el) begin
            errors++;
            $display("FAIL R%0d row %0d: actual cnt=%0d z=%0b l=%0b expected cnt=%0d z=%0b l=%0b",
                     VEC[i].req, i, count, zero_pulse, load_pulse,
                     VEC[i].ecnt, VEC[i].ez, VEC[i].el);
         end
      end

      // Directed corner cases
      do_reset();
      // R9: zero period keeps counter at zero with a pulse every cycle
      for (int k = 0; k < 3; k++) begin
         drive(1, 0, 0, 0, 0, A_OWN, 16'd0);
         chk("R9 count", {16'd0, count}, 32'd0);
         chk("R9 zero_pulse", {31'd0, zero_pulse}, 32'd1);
      end
      // R7: sync request with nothing pending is dropped
      drive(1, 0, 1, 1, 0, A_OWN, 16'd0);
      // R2: write to another slot's address is ignored
      drive(1, 0, 1, 0, 1, A_OTHER, 16'd7);
      chk("R2 foreign address", rd_data, 32'd0);
      // R10: write while disabled still lands
      drive(0, 0, 1, 0, 1, A_OWN, 16'd4);
      chk("R10 write while disabled", rd_data, 32'h0000_0004);
      chk("R10 pulse low", {31'd0, zero_pulse}, 32'd0);
      for (int k = 0; k < 2; k++) begin
         drive(0, 0, 1, 0, 0, A_OWN, 16'd0);
         chk("R10 frozen count", {16'd0, count}, 32'd0);
      end
      for (int k = 0; k < 2; k++) begin
         drive(1, 0, 1, 0, 0, A_OWN, 16'd0);
         chk("R7 early request dropped", {16'd0, count}, 32'd0);
      end
      drive(1, 0, 1, 1, 0, A_OWN, 16'd0);
      chk("R7 request latched", {16'd0, count}, 32'd0);
      drive(1, 0, 1, 0, 0, A_OWN, 16'd0);
      chk("R7 applied at zero", {16'd0, count}, 32'd4);
      drive(0, 0, 1, 0, 0, A_OWN, 16'd0);
      chk("R10 hold nonzero", {16'd0, count}, 32'd4);
      chk("R10 zero low", {31'd0, zero_pulse}, 32'd0);
      drive(1, 0, 1, 0, 0, A_OWN, 16'd0);
      chk("R3 resume", {16'd0, count}, 32'd3);
      chk("R2 reserved bits", {16'd0, rd_data[31:16]}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule